// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block drives the gates of the synchronous rectifier switches on the secondary side of a resonant converter. Each rectifier leg has its own copy of the controller. It does not depend on the primary-side switching. Each leg watches three digital flags from comparators on the switch's drain-source voltage:

- a turn-on flag, raised when the body diode starts to conduct;
- a turn-off flag, raised when the current is near zero;
- a re-arm flag, raised when the voltage crosses a positive level.

Every flag passes through a two-stage synchronizer before the state machine uses it.

Each leg has four states:

- `ST_IDLE`: armed and waiting for turn-on.
- `ST_ON_MIN`: the gate is on and the turn-off flag is masked for `MOT_CYCLES` clocks, so ringing cannot end conduction early.
- `ST_ON`: the gate is on and waiting for turn-off.
- `ST_BLANK`: the gate is off and turn-on is masked, so residual diode current cannot re-fire the switch.

The legal transitions are:

- `ST_IDLE` to `ST_ON_MIN` on the turn-on flag.
- `ST_ON_MIN` to `ST_ON` when the timer expires and the turn-off flag is low.
- `ST_ON_MIN` to `ST_BLANK` when the timer expires and the turn-off flag is high.
- `ST_ON` to `ST_BLANK` on the turn-off flag.
- `ST_BLANK` to `ST_IDLE` on the re-arm flag, or when the `BLANK_CYCLES` timeout expires.
- Any state to `ST_BLANK` when forced off.

A leg is forced off when `enable` is low or when the synchronized undervoltage flag is high.

Each gate output is registered. A one-cycle event pulse marks every rising edge and every falling edge of each gate.

Top module: `sr_gate_sequencer`

## Requirements
- R1: In `ST_IDLE`, a turn-on flag that is high at clock edge t raises the gate after edge t+2. This is two synchronizer stages plus the registered output.
- R2: Once the gate rises without a forced off, it stays high for at least `MOT_CYCLES` clock cycles, whatever the turn-off flag does.
- R3: After the minimum on-time, the turn-off flag lowers the gate. If the synchronized turn-off flag is first seen at edge E+m, where E is the gate-rise edge, the gate stays high for max(`MOT_CYCLES`, m) cycles.
- R4: In `ST_BLANK`, the turn-on flag is ignored and the gate stays low.
- R5: The synchronized re-arm flag ends `ST_BLANK`. If it is seen at edge F+j, where F is the gate-fall edge and j < `BLANK_CYCLES`, a held turn-on flag raises the gate again at edge F+j+1.
- R6: Without a re-arm flag, `ST_BLANK` ends after `BLANK_CYCLES` cycles. A held turn-on flag then raises the gate at edge F+`BLANK_CYCLES`+1.
- R7: While `rst_n` is low (asynchronous, active low), every gate and event output is low. Reset leaves each leg in `ST_BLANK`.
- R8: The legs are independent. Activity on one leg's flags never moves another leg's gate.
- R9: `enable` low at an edge lowers every gate at that edge and puts each leg in `ST_BLANK`. After `enable` returns high, a leg stays blanked until it sees a re-arm flag or the timeout expires.
- R10: The undervoltage flag is synchronized like the comparator flags. Set at a negative edge, it lowers the gates three negative edges later, and acts as R9 does.
- R11: `on_evt` and `off_evt` are one-cycle pulses aligned with the rising and falling edges of that leg's gate. Both are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable; low forces all gates off |
| uv_flag | input | 1 | Asynchronous undervoltage flag; high forces all gates off |
| on_cmp | input | NUM_LEGS | Per-leg turn-on comparator flag (body-diode conduction seen) |
| off_cmp | input | NUM_LEGS | Per-leg turn-off comparator flag (current near zero) |
| rearm_cmp | input | NUM_LEGS | Per-leg positive re-arm comparator flag |
| gate_drv | output | NUM_LEGS | Registered gate command per leg |
| on_evt | output | NUM_LEGS | One-cycle pulse at each gate turn-on |
| off_evt | output | NUM_LEGS | One-cycle pulse at each gate turn-off |

## Verification
A wrong state shows directly in the width and placement of gate pulses.

- A state machine stuck in `ST_IDLE` or `ST_ON` shows as a gate that never rises or never falls.
- A wrong timer load shifts the gate's falling edge, or its re-arm edge, by an exact number of cycles. This is visible within a single conduction cycle.
- A missing mask lets the gate rise inside the blanking window at once.

The bench sweeps the turn-off and re-arm arrival times across the whole small window, one cycle at a time. Each gate edge is therefore pinned to the exact cycle that the latency arithmetic predicts.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ON_MIN = 2'd1,
        ST_ON     = 2'd2,
        ST_BLANK  = 2'd3
    } leg_state_t;

    typedef struct packed {
        logic turn_on;
        logic turn_off;
        logic rearm;
    } cmp_flags_t;

    localparam int CMP_W = $bits(cmp_flags_t);

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/sr_phase_timer.sv
module sr_phase_timer #(
    parameter int MOT_CYCLES   = 75,
    parameter int BLANK_CYCLES = 1700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_mot,
    input  logic load_blank,
    output logic expired
);
    localparam int CNT_MAX = (MOT_CYCLES > BLANK_CYCLES) ? MOT_CYCLES - 1 : BLANK_CYCLES - 1;
    localparam int CW      = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] MOT_LOAD   = CW'(MOT_CYCLES - 1);
    localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= BLANK_LOAD;
        else if (load_mot)       cnt_q <= MOT_LOAD;
        else if (load_blank)     cnt_q <= BLANK_LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= CNT_MAX)
        else $error("timer count above its largest load value");
endmodule

// File: rtl/sr_leg_ctrl.sv
module sr_leg_ctrl
    import sr_seq_pkg::*;
#(
    parameter int MOT_CYCLES   = 75,
    parameter int BLANK_CYCLES = 1700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic on_raw,
    input  logic off_raw,
    input  logic rearm_raw,
    output logic gate,
    output logic on_evt,
    output logic off_evt
);
    cmp_flags_t flg_raw, flg;
    leg_state_t state, nxt;
    logic       tmr_done, load_mot, load_blank;
    logic       gate_q, on_evt_q, off_evt_q;
    logic       was_on, will_on;

    assign flg_raw = '{turn_on: on_raw, turn_off: off_raw, rearm: rearm_raw};

    sr_sync #(.WIDTH(CMP_W), .STAGES(2)) cmp_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (flg_raw),
        .dout (flg)
    );

    sr_phase_timer #(.MOT_CYCLES(MOT_CYCLES), .BLANK_CYCLES(BLANK_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mot  (load_mot),
        .load_blank(load_blank),
        .expired   (tmr_done)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (flg.turn_on) nxt = ST_ON_MIN;
            ST_ON_MIN: if (tmr_done)    nxt = flg.turn_off ? ST_BLANK : ST_ON;
            ST_ON:     if (flg.turn_off) nxt = ST_BLANK;
            ST_BLANK:  if (flg.rearm || tmr_done) nxt = ST_IDLE;
            default:   nxt = ST_BLANK;
        endcase
        if (force_off) nxt = ST_BLANK;
    end

    assign was_on     = (state == ST_ON_MIN) || (state == ST_ON);
    assign will_on    = (nxt == ST_ON_MIN) || (nxt == ST_ON);
    assign load_mot   = (nxt == ST_ON_MIN) && (state != ST_ON_MIN);
    assign load_blank = (nxt == ST_BLANK) && ((state != ST_BLANK) || force_off);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BLANK;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q    <= 1'b0;
            on_evt_q  <= 1'b0;
            off_evt_q <= 1'b0;
        end else begin
            gate_q    <= will_on;
            on_evt_q  <= will_on && !was_on;
            off_evt_q <= was_on && !will_on;
        end
    end

    assign gate    = gate_q;
    assign on_evt  = on_evt_q;
    assign off_evt = off_evt_q;

    assert_min_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON_MIN && !tmr_done && !force_off) |=> gate_q)
        else $error("gate dropped inside minimum on-time");

    assert_blank_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK) |=> !$rose(gate_q))
        else $error("gate rose straight out of blanking");

    assert_force_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!gate_q && state == ST_BLANK))
        else $error("forced off did not clear gate");

    assert_evt_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({on_evt_q, off_evt_q}))
        else $error("both event pulses high");

    assert_rise_evt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> on_evt_q)
        else $error("gate rose without turn-on event");
endmodule

// File: rtl/sr_gate_sequencer.sv
module sr_gate_sequencer #(
    parameter int NUM_LEGS     = 2,
    parameter int MOT_CYCLES   = 75,
    parameter int BLANK_CYCLES = 1700
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                uv_flag,
    input  logic [NUM_LEGS-1:0] on_cmp,
    input  logic [NUM_LEGS-1:0] off_cmp,
    input  logic [NUM_LEGS-1:0] rearm_cmp,
    output logic [NUM_LEGS-1:0] gate_drv,
    output logic [NUM_LEGS-1:0] on_evt,
    output logic [NUM_LEGS-1:0] off_evt
);
    logic uv_s;
    logic force_off;

    sr_sync #(.WIDTH(1), .STAGES(2)) uv_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (uv_flag),
        .dout (uv_s)
    );

    assign force_off = !enable || uv_s;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        sr_leg_ctrl #(.MOT_CYCLES(MOT_CYCLES), .BLANK_CYCLES(BLANK_CYCLES)) leg_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .force_off(force_off),
            .on_raw   (on_cmp[g]),
            .off_raw  (off_cmp[g]),
            .rearm_raw(rearm_cmp[g]),
            .gate     (gate_drv[g]),
            .on_evt   (on_evt[g]),
            .off_evt  (off_evt[g])
        );
    end

    assert_uv_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (gate_drv == '0))
        else $error("undervoltage did not clear gates");
endmodule

// File: tb/sr_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
module sr_gate_sequencer_tb_top;
    localparam int LEGS  = 2;
    localparam int MOT   = 4;
    localparam int BLANK = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b1;
    logic            uv_flag = 1'b0;
    logic [LEGS-1:0] on_cmp = '0, off_cmp = '0, rearm_cmp = '0;
    logic [LEGS-1:0] gate_drv, on_evt, off_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sr_gate_sequencer #(.NUM_LEGS(LEGS), .MOT_CYCLES(MOT), .BLANK_CYCLES(BLANK)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .uv_flag(uv_flag),
        .on_cmp(on_cmp), .off_cmp(off_cmp), .rearm_cmp(rearm_cmp),
        .gate_drv(gate_drv), .on_evt(on_evt), .off_evt(off_evt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b1; uv_flag = 1'b0;
        on_cmp = '0; off_cmp = '0; rearm_cmp = '0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic arm(input int leg);
        rearm_cmp[leg] = 1'b1;
        cycles(1);
        rearm_cmp[leg] = 1'b0;
        cycles(4);
    endtask

    // raise turn-on, confirm exact latency; leaves the sample right after the rise
    task automatic turn_on(input int leg, input string req);
        on_cmp[leg] = 1'b1;
        cycles(2);
        chk({req, " gate low before sync latency"}, gate_drv[leg], 0);
        cycles(1);
        chk({req, " gate high after sync latency"}, gate_drv[leg], 1);
        chk("R11 on_evt at rise", on_evt[leg], 1);
    endtask

    // turn-off arriving k samples after the rise
    task automatic run_pulse(input int leg, input int k);
        int hi;
        int i;
        int exp_hi;
        do_reset();
        arm(leg);
        turn_on(leg, "R1");
        on_cmp[leg] = 1'b0;
        hi = 1;
        i = 0;
        while (hi < 100) begin
            if (i == k) off_cmp[leg] = 1'b1;
            @(negedge clk);
            i++;
            if (i == 1) chk("R11 on_evt single cycle", on_evt[leg], 0);
            chk("R8 other leg idle", gate_drv[1-leg], 0);
            if (gate_drv[leg]) hi++;
            else break;
        end
        exp_hi = (k + 3 > MOT) ? k + 3 : MOT;
        chk((k + 3 > MOT) ? "R3 gate width tracks turn-off" : "R2 minimum on-time", hi, exp_hi);
        chk("R11 off_evt at fall", off_evt[leg], 1);
        off_cmp[leg] = 1'b0;
    endtask

    // blanking: turn-on held; re-arm at sample k (or never)
    task automatic run_blank(input int k, input bit use_rearm);
        int r;
        int exp_r;
        int j;
        do_reset();
        arm(0);
        turn_on(0, "R1");
        off_cmp[0] = 1'b1;
        for (int n = 0; n < 50 && gate_drv[0]; n++) @(negedge clk);
        chk("R3 gate fell", gate_drv[0], 0);
        r = 0;
        while (r < 100) begin
            if (use_rearm && r == k) rearm_cmp[0] = 1'b1;
            @(negedge clk);
            r++;
            if (gate_drv[0]) break;
        end
        if (use_rearm) begin
            j = (k + 3 < BLANK) ? k + 3 : BLANK;
            exp_r = j + 1;
            chk((k + 3 < BLANK) ? "R5 re-arm ends blanking" : "R6 timeout before re-arm", r, exp_r);
        end else begin
            exp_r = BLANK + 1;
            chk("R6 blanking timeout", r, exp_r);
        end
        chk("R4 blanked turn-on held off until arm point", r >= 4 ? 1 : 0, 1);
        on_cmp[0] = 1'b0; off_cmp[0] = 1'b0; rearm_cmp[0] = 1'b0;
    endtask

    initial begin
        // R7: outputs during and after reset
        cycles(1);
        chk("R7 gate low in reset", gate_drv, 0);
        chk("R7 events low in reset", {on_evt, off_evt}, 0);
        do_reset();
        on_cmp = '1;
        for (int n = 0; n < BLANK - 2; n++) begin
            @(negedge clk);
            chk("R7 starts blanked", gate_drv, 0);
        end
        on_cmp = '0;

        for (int leg = 0; leg < LEGS; leg++)
            for (int k = 0; k <= MOT + 3; k++)
                run_pulse(leg, k);

        for (int k = 0; k <= BLANK; k++) run_blank(k, 1'b1);
        run_blank(0, 1'b0);

        // R9: enable low forces off and re-blanks
        do_reset();
        arm(0);
        turn_on(0, "R9 setup");
        enable = 1'b0;
        @(negedge clk);
        chk("R9 gate off after enable low", gate_drv[0], 0);
        chk("R11 off_evt on forced off", off_evt[0], 1);
        enable = 1'b1;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            chk("R9 stays blanked after re-enable", gate_drv[0], 0);
        end
        on_cmp = '0;

        // R10: undervoltage with synchronizer latency
        do_reset();
        arm(0);
        turn_on(0, "R10 setup");
        uv_flag = 1'b1;
        cycles(2);
        chk("R10 gate still high before uv sync", gate_drv[0], 1);
        cycles(1);
        chk("R10 gate off by undervoltage", gate_drv[0], 0);
        uv_flag = 1'b0;
        cycles(3);
        chk("R10 stays blanked after uv clears", gate_drv[0], 0);
        on_cmp = '0;

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule